// File: doc/BRIEF.md
# Banked Strided Vector Access Controller

This block walks the element addresses of a strided vector load or store and spreads them over a set of independently addressed memory banks. A start strobe captures a base word address, a signed stride in words and an element count. The controller then produces element `i` at address `base + i*stride`, strictly in element order. The low bits of each word address pick a bank, and the remaining upper bits form the address inside that bank.

Each bank stays occupied for a fixed number of cycles after it is accessed. The controller keeps one countdown timer per bank. When the next element falls on a bank that is still occupied, that element waits and the stall output is raised. Throughput therefore depends on the stride. A stride that visits the banks in rotation streams one element per cycle. A stride that keeps landing on the same bank slows to one element per bank busy time. A one-cycle completion flag follows the final access.

Top module: `strided_bank_ctrl`

## Requirements
- R1: While reset is asserted, and in idle cycles after it, no bank request, stall or completion is signalled.
- R2: Element `i` targets word address `(base + i*stride) mod 2^ADDR_W`. Its bank is the address modulo NBANK (the low log2(NBANK) bits). Its bank-local address (the address divided by NBANK) appears on slice `b` of `bank_addr_o`, bits `[b*LAW +: LAW]` with `LAW = ADDR_W - log2(NBANK)`. Slices of banks that are not requested are zero.
- R3: At most one bank request is raised per cycle. The first element is attempted in the cycle after the start strobe is sampled, and elements are issued strictly in element order.
- R4: A bank accessed in cycle t is not requested again before cycle t+BUSY. `stall_o` is high in exactly those cycles in which the pending element's bank is still occupied, and the element issues in the first cycle its bank is free.
- R5: When no bank conflict arises, one element is issued every cycle, so N elements finish with completion in the Nth cycle after the first attempt.
- R6: `done_o` is high for the one cycle that follows the last issued element. A start with count zero issues nothing and raises `done_o` in the cycle after the start is sampled.
- R7: A start strobe that arrives while an operation is in progress is ignored: the running operation's addresses and timing are unchanged.
- R8: Bank occupancy carries across operations: a new operation that reaches a bank still occupied from the previous one stalls.
- R9: A negative stride is taken in two's complement, and addresses wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe, sampled only while idle |
| base_i | input | ADDR_W | Word address of element 0 |
| stride_i | input | ADDR_W | Signed stride in words between consecutive elements |
| count_i | input | CNT_W | Number of elements |
| bank_req_o | output | NBANK | One request strobe per bank |
| bank_addr_o | output | NBANK*LAW | Bank-local address, one LAW-bit slice per bank |
| stall_o | output | 1 | Pending element waits on an occupied bank |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A bank-conflict stall and the arrival of a new start strobe can fall in the same cycle. The bench provokes this by running a stride that hits one bank repeatedly and pulsing start during a stall cycle, with a different base, stride and count. It judges the result with a cycle-level reference model that ignores such a strobe: every cycle's requests, bank-local addresses, stall and completion must match the first operation, and its total latency must equal the hand-computed value. A second overlap is a new operation whose first element meets a bank still occupied by the previous operation; the bench checks that this stall appears in the new operation's first cycle.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_e;
endpackage

// File: rtl/sbc_rst_sync.sv
module sbc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sbc_addr_seq.sv
module sbc_addr_seq
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              issue_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              active_o,
  output logic              done_o
);
  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] stride_q, stride_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              done_q, done_d;
  logic              ctx_en;

  // next-state
  always_comb begin
    phase_d  = phase_q;
    addr_d   = addr_q;
    stride_d = stride_q;
    rem_d    = rem_q;
    done_d   = 1'b0;
    ctx_en   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          if (count_i == '0) begin
            done_d = 1'b1;
          end else begin
            ctx_en   = 1'b1;
            phase_d  = PH_RUN;
            addr_d   = base_i;
            stride_d = stride_i;
            rem_d    = count_i;
          end
        end
      end
      PH_RUN: begin
        if (issue_i) begin
          ctx_en = 1'b1;
          addr_d = addr_q + stride_q;
          rem_d  = rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
      rem_q    <= '0;
    end else if (ctx_en) begin
      addr_q   <= addr_d;
      stride_q <= stride_d;
      rem_q    <= rem_d;
    end
  end

  assign cur_addr_o = addr_q;
  assign active_o   = (phase_q == PH_RUN);
  assign done_o     = done_q;
endmodule

// File: rtl/sbc_bank_timers.sv
module sbc_bank_timers #(
  parameter int NBANK = 4,
  parameter int BUSY  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] fire_i,
  output logic [NBANK-1:0] free_o
);
  localparam int TMR_W = (BUSY > 1) ? $clog2(BUSY) : 1;
  localparam logic [TMR_W-1:0] RELOAD = TMR_W'(BUSY - 1);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [TMR_W-1:0] cnt_q, cnt_d;
    logic             cnt_en;

    always_comb begin
      cnt_en = fire_i[b] || (cnt_q != '0);
      if (fire_i[b]) cnt_d = RELOAD;
      else           cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign free_o[b] = (cnt_q == '0);
  end
endmodule

// File: rtl/sbc_issue.sv
module sbc_issue #(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 16,
  localparam int BW    = $clog2(NBANK),
  localparam int LAW   = ADDR_W - BW
) (
  input  logic                 active_i,
  input  logic [ADDR_W-1:0]    cur_addr_i,
  input  logic [NBANK-1:0]     free_i,
  output logic                 issue_o,
  output logic                 stall_o,
  output logic [NBANK-1:0]     req_o,
  output logic [NBANK*LAW-1:0] addr_o
);
  logic [BW-1:0]  sel;
  logic [LAW-1:0] local_addr;
  logic           sel_free;

  always_comb begin
    sel        = cur_addr_i[BW-1:0];
    local_addr = cur_addr_i[ADDR_W-1:BW];
    sel_free   = free_i[sel];
    issue_o    = active_i && sel_free;
    stall_o    = active_i && !sel_free;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_out
    assign req_o[b]               = issue_o && (sel == BW'(b));
    assign addr_o[b*LAW +: LAW]   = req_o[b] ? local_addr : '0;
  end
endmodule

// File: rtl/strided_bank_ctrl.sv
module strided_bank_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int NBANK  = 4,
  parameter int BUSY   = 3,
  localparam int BW    = $clog2(NBANK),
  localparam int LAW   = ADDR_W - BW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [ADDR_W-1:0]    stride_i,
  input  logic [CNT_W-1:0]     count_i,
  output logic [NBANK-1:0]     bank_req_o,
  output logic [NBANK*LAW-1:0] bank_addr_o,
  output logic                 stall_o,
  output logic                 done_o
);
  logic              rst_n_s;
  logic [ADDR_W-1:0] cur_addr;
  logic              active;
  logic              issue;
  logic [NBANK-1:0]  free;

  sbc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sbc_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_i),
    .base_i     (base_i),
    .stride_i   (stride_i),
    .count_i    (count_i),
    .issue_i    (issue),
    .cur_addr_o (cur_addr),
    .active_o   (active),
    .done_o     (done_o)
  );

  sbc_bank_timers #(.NBANK(NBANK), .BUSY(BUSY)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .fire_i (bank_req_o),
    .free_o (free)
  );

  sbc_issue #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_iss (
    .active_i   (active),
    .cur_addr_i (cur_addr),
    .free_i     (free),
    .issue_o    (issue),
    .stall_o    (stall_o),
    .req_o      (bank_req_o),
    .addr_o     (bank_addr_o)
  );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int NBANK = 4,
  parameter int BUSY  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] bank_req_o,
  input logic             stall_o,
  input logic             done_o
);
  // R3: never more than one bank request in a cycle
  a_r3_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_req_o));

  // R4: a stalled cycle issues nothing
  a_r4_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (bank_req_o == '0));

  // R6: the completion cycle carries no access and no stall
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((bank_req_o == '0) && !stall_o));

  // R4: a bank is not hit in back-to-back cycles when its busy time exceeds one
  if (BUSY > 1) begin : g_gap
    for (genvar b = 0; b < NBANK; b++) begin : g_b
      a_r4_bank_gap: assert property (@(posedge clk) disable iff (!rst_n)
        bank_req_o[b] |=> !bank_req_o[b]);
    end
  end
endmodule

bind strided_bank_ctrl sbc_checker #(.NBANK(NBANK), .BUSY(BUSY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bank_req_o (bank_req_o),
  .stall_o    (stall_o),
  .done_o     (done_o)
);

// File: tb/strided_bank_ctrl_test.sv
module strided_bank_ctrl_test;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int NB     = 8;
  localparam int BUSY   = 5;
  localparam int LAW    = ADDR_W - $clog2(NB);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start_i = 1'b0;
  logic [ADDR_W-1:0]    base_i = '0;
  logic [ADDR_W-1:0]    stride_i = '0;
  logic [CNT_W-1:0]     count_i = '0;
  logic [NB-1:0]        bank_req_o;
  logic [NB*LAW-1:0]    bank_addr_o;
  logic                 stall_o;
  logic                 done_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  // reference model state
  int                m_t [NB];
  logic              m_act = 1'b0;
  logic              m_done = 1'b0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [ADDR_W-1:0] m_stride = '0;
  int                m_rem = 0;
  logic              saw_stall;

  always #4 clk = ~clk;  // 125 MHz

  strided_bank_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NBANK(NB), .BUSY(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .stride_i(stride_i), .count_i(count_i), .bank_req_o(bank_req_o),
    .bank_addr_o(bank_addr_o), .stall_o(stall_o), .done_o(done_o)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual cycles %0d expected below 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // compare one cycle against the model, advance the model, move to next negedge
  task automatic step(input string tag);
    logic [NB-1:0]  er;
    logic [LAW-1:0] ea;
    logic           es, ed, iss, nd, act_old;
    int             b;
    er = '0; ea = '0; es = 1'b0; ed = m_done; iss = 1'b0; nd = 1'b0;
    b = int'(m_addr % NB);
    act_old = m_act;
    if (m_act) begin
      if (m_t[b] == 0) begin
        iss = 1'b1; er[b] = 1'b1; ea = LAW'(m_addr / NB);
      end else es = 1'b1;
    end
    if (stall_o === 1'b1) saw_stall = 1'b1;
    chk(bank_req_o === er, "R3", {tag, " bank_req"}, bank_req_o, er);
    chk(stall_o === es, "R4", {tag, " stall"}, stall_o, es);
    chk(done_o === ed, "R6", {tag, " done"}, done_o, ed);
    if (iss) chk(bank_addr_o[b*LAW +: LAW] === ea, "R2", {tag, " local addr"},
                 bank_addr_o[b*LAW +: LAW], ea);
    for (int k = 0; k < NB; k++) if (m_t[k] > 0) m_t[k]--;
    if (iss) begin
      m_t[b] = BUSY - 1;
      m_addr = m_addr + m_stride;
      m_rem--;
      if (m_rem == 0) begin m_act = 1'b0; nd = 1'b1; end
    end
    if (start_i && !act_old) begin
      if (count_i == '0) nd = 1'b1;
      else begin m_act = 1'b1; m_addr = base_i; m_stride = stride_i; m_rem = int'(count_i); end
    end
    m_done = nd;
    @(negedge clk);
  endtask

  // launch one operation; returns cycles from first attempt until done
  task automatic run_op(input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] s,
                        input int n, input string tag, input int poke_at, output int lat);
    base_i = b; stride_i = s; count_i = CNT_W'(n); start_i = 1'b1;
    step(tag);
    start_i = 1'b0;
    base_i = 16'h0100; stride_i = 16'h0001; count_i = 8'd9;
    saw_stall = 1'b0;
    lat = -1;
    for (int i = 0; i < 400; i++) begin
      start_i = (i == poke_at);
      if (done_o === 1'b1) begin lat = i; start_i = 1'b0; step(tag); break; end
      step(tag);
    end
    start_i = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic t_reset();
    for (int k = 0; k < NB; k++) m_t[k] = 0;
    @(negedge clk);
    chk(bank_req_o === '0, "R1", "reset req", bank_req_o, 0);
    chk(stall_o === 1'b0, "R1", "reset stall", stall_o, 0);
    chk(done_o === 1'b0, "R1", "reset done", done_o, 0);
    rst_n = 1'b1;
    idle(4, "R1 post-reset idle");
  endtask

  task automatic t_unit();  // R5 R2
    int lat;
    run_op(16'd5, 16'd1, 10, "R5 unit stride", -1, lat);
    chk(lat == 10, "R5", "unit stride latency", lat, 10);
    chk(saw_stall == 1'b0, "R5", "unit stride no stall", saw_stall, 0);
    idle(BUSY, "R5 gap");
  endtask

  task automatic t_same_bank();  // R4
    int lat;
    run_op(16'd3, 16'd8, 3, "R4 same bank", -1, lat);
    chk(lat == 11, "R4", "same bank latency", lat, 11);
    idle(BUSY, "R4 gap");
  endtask

  task automatic t_stride2();  // R4
    int lat;
    run_op(16'd0, 16'd2, 6, "R4 stride2", -1, lat);
    chk(lat == 7, "R4", "stride2 latency", lat, 7);
    idle(BUSY, "R4 gap2");
  endtask

  task automatic t_negative();  // R9
    int lat;
    run_op(16'd2, 16'hFFFF, 6, "R9 negative", -1, lat);
    chk(lat == 6, "R9", "negative stride latency", lat, 6);
    idle(BUSY, "R9 gap");
  endtask

  task automatic t_zero();  // R6
    int lat;
    run_op(16'd7, 16'd1, 0, "R6 zero count", -1, lat);
    chk(lat == 0, "R6", "zero count done timing", lat, 0);
    idle(2, "R6 gap");
  endtask

  task automatic t_ignore();  // R7
    int lat;
    run_op(16'd16, 16'd8, 3, "R7 ignored start", 2, lat);
    chk(lat == 11, "R7", "latency with ignored start", lat, 11);
    idle(BUSY + 2, "R7 after");
  endtask

  task automatic t_carry();  // R8
    int lat;
    run_op(16'd0, 16'd8, 1, "R8 first", -1, lat);
    run_op(16'd8, 16'd1, 2, "R8 second", -1, lat);
    chk(saw_stall == 1'b1, "R8", "carry-over stall seen", saw_stall, 1);
    chk(lat == 4, "R8", "carry-over latency", lat, 4);
    idle(BUSY, "R8 gap");
  endtask

  task automatic t_odd();  // R5 R2 with wrap
    int lat;
    run_op(16'hFFF0, 16'd3, 12, "R2 odd stride wrap", -1, lat);
    chk(lat == 12, "R5", "odd stride latency", lat, 12);
    idle(BUSY, "R2 gap");
  endtask

  initial begin
    t_reset();
    t_unit();
    t_same_bank();
    t_stride2();
    t_negative();
    t_zero();
    t_ignore();
    t_carry();
    t_odd();
    summary();
    $finish;
  end
endmodule